// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs the external memory bus of a small 8-bit controller core. Time is split into machine cycles of twelve clocks. In the last clock of each machine cycle the core offers one request: an idle cycle, an opcode fetch, a data read or a data write. The block then spends the next machine cycle driving the address-latch strobe, the program-read strobe, the data read and write strobes, the shared low address/data byte and the high address byte, and it returns the byte it captures from the bus.

An opcode-fetch machine cycle holds two fetch slots. The first slot fetches the requested address and the second fetches the address plus one, each in its own half cycle. A select bit is latched while reset is held. When that bit is high, a fetch slot whose address is under a parameterised limit (8192 by default) is served from on-chip memory. Such a slot leaves the program strobe idle and releases the low byte lane, and the address strobe keeps its steady rate. A data cycle drops the second address-strobe pulse and both program-strobe pulses. A data cycle with a 16-bit address puts the high address byte on the upper port. A data cycle with an 8-bit address puts the core's port latch there instead.

Top module: `ebus_seq`

## Requirements
- R1: A machine cycle is 12 clocks (phases 0..11). `mc_last` is high exactly in phase 11, and the request inputs (`req_op`, `req_addr`, `req_wide`, `req_wdata`) are sampled only on the clock edge that ends phase 11. Changing them in any other phase has no effect on the cycle under way. The op encoding is 0 idle, 1 fetch, 2 data read, 3 data write.
- R2: `ale` is high in phases 0, 1, 6 and 7 of idle and fetch cycles. In data read and write cycles it is high only in phases 0 and 1.
- R3: In a fetch cycle, slot 0 covers phases 0..5 at address A and slot 1 covers phases 6..11 at address A+1 (modulo 2^16). `psen_n` is low in phases 3..5 of an external slot and high at all other times. Idle, read and write cycles keep `psen_n` high.
- R4: `psen_n` falls exactly one clock after `ale` falls, and `ale` was high in the clock before that.
- R5: `rd_n` is low in phases 3..8 of a read cycle and `wr_n` is low in phases 3..8 of a write cycle. The two are never low together.
- R6: `p0_oe` drives the low address byte in phases 0..2 of every external fetch slot (phases 0..2 and 6..8 of the cycle) and in phases 0..2 of every data cycle. A write cycle then drives the write data in phases 3..9. The lane is released at all other times, including the whole strobe window of a read.
- R7: `p2_out` carries the slot address high byte during an external fetch slot and the address high byte for a whole data cycle with `req_wide`=1. In every other case (8-bit data, idle, internal slot) it carries `p2_latch`.
- R8: `p0_in` is captured on the edge at which `psen_n` or `rd_n` returns high. `rdata_vld` then pulses for one clock: in phase 6 for slot 0, in phase 0 of the following cycle for slot 1, and in phase 9 for a read.
- R9: `ea_in` is latched while reset is held and through the two-clock reset release, and it is ignored after that. With the latched value 1, a fetch slot whose address is below 8192 is internal: `psen_n` stays high, `p0_oe` stays low and no `rdata_vld` follows. With the latched value 0, every fetch slot is external.
- R10: While `rst_n` is low, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `rdata_vld`=0 and `mc_last`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_in | input | 1 | Program-space select, latched during reset |
| req_op | input | 2 | Request kind: 0 idle, 1 fetch, 2 read, 3 write |
| req_addr | input | 16 | Request address (fetch base or data address) |
| req_wide | input | 1 | Data address width: 1 = 16-bit, 0 = 8-bit |
| req_wdata | input | 8 | Write data byte |
| p2_latch | input | 8 | Upper-port latch contents from the core |
| p0_in | input | 8 | Sampled low byte lane |
| mc_last | output | 1 | High in the final phase; the request is taken at its end |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low byte lane drive value |
| p0_oe | output | 1 | Low byte lane output enable |
| p2_out | output | 8 | Upper port value |
| rdata | output | 8 | Captured instruction or data byte |
| rdata_vld | output | 1 | One-clock pulse when `rdata` is new |

## Verification
The bench sweeps every request kind over eight addresses chosen around the on-chip limit and the 16-bit wrap (0x1FFF, 0x2000, 0xFFFF among them), with both address widths for data cycles. It runs under both latched select values and checks every output in every phase against a model built from the phase rules. Fetches at 0x1FFF and 0xFFFF have one internal and one external slot, so a design that decides internal or external once per cycle, or that forgets the +1 on the second slot, fails those cases. Changing the request inputs in mid-cycle and flipping the select input after reset show that both are ignored outside their sampling windows. Narrow against wide data cycles separate the two sources of the upper port.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FETCH = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } bus_op_e;
endpackage

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr #(
  parameter int MC_LEN = 12,
  parameter int PH_W   = $clog2(MC_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ea_in,
  output logic [PH_W-1:0] ph,
  output logic            run,
  output logic            mc_last,
  output logic            ea_lat
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(MC_LEN - 1);

  logic            rs_meta;
  logic            run_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;
  logic            ea_q;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      run_q   <= rs_meta;
    end
  end

  always_comb begin
    if (!run_q)
      ph_nxt = LAST_PH;
    else if (ph_q == LAST_PH)
      ph_nxt = '0;
    else
      ph_nxt = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= LAST_PH;
    else        ph_q <= ph_nxt;
  end

  // program-space select: loads only while the block is held in reset
  always_ff @(posedge clk) begin
    if (!run_q) ea_q <= ea_in;
  end

  assign ph      = ph_q;
  assign run     = run_q;
  assign mc_last = run_q && (ph_q == LAST_PH);
  assign ea_lat  = ea_q;

  // R1
  last_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_last |=> !mc_last);

  // R9
  ea_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(ea_q));
endmodule

// File: rtl/ebus_strobes.sv
module ebus_strobes
  import ebus_pkg::*;
#(
  parameter int MC_LEN = 12,
  parameter int PH_W   = $clog2(MC_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph,
  input  bus_op_e         op,
  input  logic            ext0,
  input  logic            ext1,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n
);
  localparam int ALE_W   = 2;
  localparam int HALF    = MC_LEN / 2;
  localparam logic [PH_W-1:0] HALF_P  = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_P   = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] STB_P   = PH_W'(ALE_W + 1);
  localparam logic [PH_W-1:0] STB_END = PH_W'(ALE_W + HALF);

  logic            in_hi;
  logic [PH_W-1:0] off;
  logic            is_data;
  logic            slot_ext;

  always_comb begin
    in_hi    = (ph >= HALF_P);
    off      = in_hi ? (ph - HALF_P) : ph;
    is_data  = (op == OP_RD) || (op == OP_WR);
    slot_ext = in_hi ? ext1 : ext0;
    ale      = (off < ALE_P) && (!in_hi || !is_data);
    psen_n   = !((op == OP_FETCH) && slot_ext && (off >= STB_P));
    rd_n     = !((op == OP_RD) && (ph >= STB_P) && (ph <= STB_END));
    wr_n     = !((op == OP_WR) && (ph >= STB_P) && (ph <= STB_END));
  end

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  // R4
  psen_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
endmodule

// File: rtl/ebus_lane_mux.sv
module ebus_lane_mux
  import ebus_pkg::*;
#(
  parameter int MC_LEN = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PH_W   = $clog2(MC_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   ph,
  input  bus_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] p2_latch,
  input  logic              ext0,
  input  logic              ext1,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  localparam int ALE_W = 2;
  localparam int HALF  = MC_LEN / 2;
  localparam logic [PH_W-1:0] HALF_P   = PH_W'(HALF);
  localparam logic [PH_W-1:0] AHOLD_P  = PH_W'(ALE_W + 1);
  localparam logic [PH_W-1:0] SLOT_END = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] RD_END   = PH_W'(ALE_W + HALF);
  localparam logic [PH_W-1:0] WD_END   = PH_W'(ALE_W + HALF + 1);

  logic              in_hi;
  logic [PH_W-1:0]   off;
  logic [ADDR_W-1:0] slot_addr;
  logic              slot_ext;
  logic              cap;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              vld_q, vld_d;

  always_comb begin
    in_hi     = (ph >= HALF_P);
    off       = in_hi ? (ph - HALF_P) : ph;
    slot_addr = in_hi ? (addr + ADDR_W'(1)) : addr;
    slot_ext  = in_hi ? ext1 : ext0;
    p0_oe     = 1'b0;
    p0_out    = '0;
    p2_out    = p2_latch;
    unique case (op)
      OP_FETCH: begin
        if (slot_ext) begin
          p2_out = slot_addr[ADDR_W-1:DATA_W];
          if (off < AHOLD_P) begin
            p0_oe  = 1'b1;
            p0_out = slot_addr[DATA_W-1:0];
          end
        end
      end
      OP_RD, OP_WR: begin
        if (wide) p2_out = addr[ADDR_W-1:DATA_W];
        if (ph < AHOLD_P) begin
          p0_oe  = 1'b1;
          p0_out = addr[DATA_W-1:0];
        end else if ((op == OP_WR) && (ph <= WD_END)) begin
          p0_oe  = 1'b1;
          p0_out = wdata;
        end
      end
      default: ;
    endcase
  end

  // capture on the clock edge that ends the strobe
  always_comb begin
    cap     = ((op == OP_FETCH) && slot_ext && (off == SLOT_END)) ||
              ((op == OP_RD) && (ph == RD_END));
    vld_d   = cap;
    rdata_d = cap ? p0_in : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
    end
  end

  assign rdata     = rdata_q;
  assign rdata_vld = vld_q;

  // R8
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |=> !rdata_vld);
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int MC_LEN    = 12,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ea_in,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] p2_latch,
  input  logic [DATA_W-1:0] p0_in,
  output logic              mc_last,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  localparam int PH_W = $clog2(MC_LEN);
  localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W+1)'(INT_LIMIT);

  logic [PH_W-1:0]   ph;
  logic              run;
  logic              ea_lat;
  bus_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wide_q, wide_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [ADDR_W-1:0] addr_p1;
  logic              ext0, ext1;

  ebus_phase_ctr #(.MC_LEN(MC_LEN), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ea_in(ea_in),
    .ph(ph), .run(run), .mc_last(mc_last), .ea_lat(ea_lat)
  );

  // request register: loaded only in the final phase
  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    wide_d = wide_q;
    wd_d   = wd_q;
    if (mc_last) begin
      op_d   = bus_op_e'(req_op);
      addr_d = req_addr;
      wide_d = req_wide;
      wd_d   = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      wide_q <= 1'b0;
      wd_q   <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      wide_q <= wide_d;
      wd_q   <= wd_d;
    end
  end

  // per-slot program-space decision
  always_comb begin
    addr_p1 = addr_q + ADDR_W'(1);
    ext0    = !(ea_lat && ({1'b0, addr_q}  < LIMIT_V));
    ext1    = !(ea_lat && ({1'b0, addr_p1} < LIMIT_V));
  end

  ebus_strobes #(.MC_LEN(MC_LEN), .PH_W(PH_W)) u_strobes (
    .clk(clk), .rst_n(rst_n), .ph(ph), .op(op_q),
    .ext0(ext0), .ext1(ext1),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  ebus_lane_mux #(.MC_LEN(MC_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .ph(ph), .op(op_q),
    .addr(addr_q), .wide(wide_q), .wdata(wd_q), .p2_latch(p2_latch),
    .ext0(ext0), .ext1(ext1), .p0_in(p0_in),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // R6
  rd_lane_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  // R3
  data_no_psen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n);

  // R10
  idle_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (psen_n && rd_n && wr_n && !ale));
endmodule

// File: tb/ebus_seq_tb.sv
module ebus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ea_in;
  logic [1:0]  req_op;
  logic [15:0] req_addr;
  logic        req_wide;
  logic [7:0]  req_wdata;
  logic [7:0]  p2_latch;
  logic [7:0]  p0_in;
  logic        mc_last, ale, psen_n, rd_n, wr_n, p0_oe, rdata_vld;
  logic [7:0]  p0_out, p2_out, rdata;

  int total = 0;
  int bad   = 0;
  bit ea_m;
  bit pend;
  logic [7:0] pend_val;
  bit done = 0;

  always #5 clk = ~clk;

  ebus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ea_in(ea_in),
    .req_op(req_op), .req_addr(req_addr), .req_wide(req_wide), .req_wdata(req_wdata),
    .p2_latch(p2_latch), .p0_in(p0_in),
    .mc_last(mc_last), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic bit is_ext(input logic [15:0] a);
    return !(ea_m && (a < 16'h2000));
  endfunction

  task automatic do_reset(input bit ea);
    rst_n = 1'b0;
    ea_in = ea;
    req_op = 2'd0; req_addr = '0; req_wide = 1'b0; req_wdata = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 ale", 16'(ale), 16'd0);
    chk("R10 psen_n", 16'(psen_n), 16'd1);
    chk("R10 rd_n/wr_n", 16'({rd_n, wr_n}), 16'd3);
    chk("R10 p0_oe", 16'(p0_oe), 16'd0);
    chk("R10 rdata_vld", 16'(rdata_vld), 16'd0);
    chk("R10 mc_last", 16'(mc_last), 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 10 && !mc_last; i++) @(negedge clk);
    chk("R1 first mc_last", 16'(mc_last), 16'd1);
    ea_in = ~ea;   // R9: must be ignored from here on
    ea_m  = ea;
    pend  = 1'b0;
  endtask

  task automatic do_cycle(input logic [1:0] op, input logic [15:0] a, input bit wide,
                          input logic [7:0] wd);
    logic [15:0] a1, sa;
    bit e0, e1, hi, se, is_data, e_ale, e_psen, e_rd, e_wr, e_oe, e_vld;
    int off;
    logic [7:0] e_p0, e_p2, e_rdata;
    a1 = a + 16'd1;
    e0 = (op == 2'd1) && is_ext(a);
    e1 = (op == 2'd1) && is_ext(a1);
    is_data = op[1];
    req_op = op; req_addr = a; req_wide = wide; req_wdata = wd;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 2) begin
        // R1: mid-cycle request changes are ignored
        req_op = ~op; req_addr = ~a; req_wide = ~wide; req_wdata = ~wd;
      end
      if (k == 3) p0_in = pat(a);
      if (k == 9) p0_in = pat(a1);
      hi  = (k >= 6);
      off = hi ? k - 6 : k;
      sa  = hi ? a1 : a;
      se  = hi ? e1 : e0;
      e_ale  = (off < 2) && (!hi || !is_data);
      e_psen = !((op == 2'd1) && se && (off >= 3));
      e_rd   = !((op == 2'd2) && (k >= 3) && (k <= 8));
      e_wr   = !((op == 2'd3) && (k >= 3) && (k <= 8));
      if (op == 2'd1)  e_oe = se && (off < 3);
      else if (is_data) e_oe = (k < 3) || ((op == 2'd3) && (k <= 9));
      else              e_oe = 1'b0;
      e_p0 = !e_oe ? 8'h00 : ((op == 2'd3 && k >= 3) ? wd : sa[7:0]);
      if (op == 2'd1)          e_p2 = se ? sa[15:8] : p2_latch;
      else if (is_data && wide) e_p2 = a[15:8];
      else                     e_p2 = p2_latch;
      if (k == 0)      begin e_vld = pend;              e_rdata = pend_val; end
      else if (k == 6) begin e_vld = (op == 2'd1) && e0; e_rdata = pat(a);  end
      else if (k == 9) begin e_vld = (op == 2'd2);       e_rdata = pat(a);  end
      else             begin e_vld = 1'b0;               e_rdata = 8'h00;   end
      chk("R1 mc_last", 16'(mc_last), 16'(k == 11));
      chk("R2 ale", 16'(ale), 16'(e_ale));
      chk((ea_m ? "R3/R9 psen_n" : "R3 psen_n"), 16'(psen_n), 16'(e_psen));
      chk("R5 rd_n", 16'(rd_n), 16'(e_rd));
      chk("R5 wr_n", 16'(wr_n), 16'(e_wr));
      chk("R6 p0_oe", 16'(p0_oe), 16'(e_oe));
      chk("R6 p0_out", 16'(p0_out & {8{p0_oe}}), 16'(e_p0));
      chk("R7 p2_out", 16'(p2_out), 16'(e_p2));
      chk("R8 rdata_vld", 16'(rdata_vld), 16'(e_vld));
      if (e_vld) chk("R8 rdata", 16'(rdata), 16'(e_rdata));
    end
    pend     = e1;
    pend_val = pat(a1);
  endtask

  logic [15:0] addrs [8];

  initial begin
    addrs[0] = 16'h0000; addrs[1] = 16'h0010; addrs[2] = 16'h1FFF; addrs[3] = 16'h2000;
    addrs[4] = 16'h2345; addrs[5] = 16'h7FFE; addrs[6] = 16'hA5C3; addrs[7] = 16'hFFFF;
    p0_in = 8'h00;
    for (int pass = 0; pass < 2; pass++) begin
      p2_latch = (pass == 0) ? 8'hC3 : 8'h5E;
      do_reset(pass == 0);
      for (int ai = 0; ai < 8; ai++) begin
        for (int op = 0; op < 4; op++) begin
          for (int w = 0; w < 2; w++) begin
            if (op < 2 && w == 1) continue;
            do_cycle(2'(op), addrs[ai], w[0], addrs[ai][7:0] + 8'h11);
          end
        end
      end
      do_cycle(2'd0, 16'h0000, 1'b0, 8'h00);  // flush last slot-1 capture
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule